// File: doc/BRIEF.md
# Boot and Instruction Fetch Sequencer

This block is the front end of a small 8-bit accumulator processor that has a 12-bit address bus. When reset is released it runs a three-step boot. It reads the high and low halves of the program start address from the two locations just below the top of memory. It then reads a stack page number from the topmost location. After boot it fetches instructions, reading one byte from memory in each clock.

The opcode byte alone tells the sequencer how many operand bytes follow it: none, one or two. Once the last byte of an instruction is in, the sequencer issues the opcode and operands to an execute stage with a one-cycle start pulse. It then waits for that stage to report done before it fetches again, so an instruction that takes several cycles stalls the fetch.

The sequencer only reads memory. Memory responds within the same cycle. The execute stage is outside the block, and it is told through a clear strobe when to reset its working registers at boot.

Top module: `fetch_seq`

## Requirements
- R1: The block never writes. `memRdWrN` is 1 and `memDataOe` is 0 in every cycle.
- R2: While `rstN` is low, all of the following hold: `memAddr` is 0xFFD; `halted`, `bootDone` and `execStart` are 0; `fetchPc`, `stackBank` and `stackPtr` are 0.
- R3: After reset is released, the block reads 0xFFD, 0xFFE and 0xFFF in three consecutive cycles with `bootDone` low. The start PC is ((byte@0xFFD << 8) + byte@0xFFE) modulo 4096. From the next cycle on, `bootDone` is 1, `stackBank` equals byte@0xFFF and `stackPtr` is 0xFF.
- R4: `execClear` is 1 during reset and during the 0xFFD boot read, and 0 in every other cycle.
- R5: The opcode fixes the operand count: below 0x50 takes none, 0x50 to 0xAF takes one, and 0xB0 or above takes two. Operands are read in the cycles right after the opcode, at consecutive addresses, and `memAddr` equals `fetchPc` in each fetch cycle.
- R6: `fetchPc` goes up by one after each opcode or operand read, and wraps from 0xFFF to 0x000.
- R7: `execStart` is a one-cycle pulse in the cycle after the last byte of an instruction is read. In that cycle, `execOpcode` holds the opcode, `execArgs[7:0]` holds the first operand and `execArgs[15:8]` holds the second. An operand the opcode does not take reads as 0x00.
- R8: After `execStart`, `execDone` is sampled from the next cycle on. No read is made and `fetchPc` holds until that point. The next opcode is read in the cycle after `execDone` is seen high.
- R9: Opcode 0x00 issues nothing. `halted` goes to 1 in the next cycle and stays at 1, with no `execStart`, until reset.
- R10: Every opcode value other than 0x00, including the unassigned ones, is fetched and issued in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | 12 | Memory address |
| memRdWrN | output | 1 | 1 = read, 0 = write |
| memDataOe | output | 1 | Data bus output enable |
| memDataIn | input | 8 | Read data, valid in the cycle of its address |
| execStart | output | 1 | One-cycle issue pulse to the execute stage |
| execOpcode | output | 8 | Opcode of the issued instruction |
| execArgs | output | 16 | Operands: first in [7:0], second in [15:8] |
| execDone | input | 1 | Execute stage has finished |
| execClear | output | 1 | Clear the execute stage's working registers |
| fetchPc | output | 12 | Program counter |
| stackBank | output | 8 | Stack page read at boot |
| stackPtr | output | 8 | Initial stack pointer |
| bootDone | output | 1 | Boot sequence complete |
| halted | output | 1 | Halt opcode seen |

## Verification
The bench uses the default parameters: a 12-bit address, 8-bit data, at most two operands, and length thresholds at 0x50 and 0xB0. With these values a full 4096-byte memory image sits in the bench. A program can therefore start near 0xFFF, run through the boot bytes as instruction bytes, and wrap to 0x000 in the middle of an instruction. Opcodes on each side of both thresholds and the 0xFF extreme are issued. The execute stage's done latency varies from one to three cycles per instruction, and a reset arrives in the middle of a run.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;

  // address source chosen by the control for the current cycle
  typedef enum logic [1:0] {
    ADDR_PC        = 2'd0,
    ADDR_BOOT_HI   = 2'd1,
    ADDR_BOOT_LO   = 2'd2,
    ADDR_BOOT_BANK = 2'd3
  } addrSel_e;

  typedef enum logic [2:0] {
    S_BOOT_HI   = 3'd0,
    S_BOOT_LO   = 3'd1,
    S_BOOT_BANK = 3'd2,
    S_OPCODE    = 3'd3,
    S_ARG       = 3'd4,
    S_ISSUE     = 3'd5,
    S_WAIT      = 3'd6,
    S_HALT      = 3'd7
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    addrSel_e addrSel;
    logic     capHi;
    logic     capLo;
    logic     capBank;
    logic     capOpcode;
    logic     capArg;
    logic     pcInc;
  } ctrlStrobes_t;

endpackage

// File: rtl/fseq_len_dec.sv
`timescale 1ns/1ps
module fseq_len_dec #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2,
  parameter logic [DATA_W-1:0] ONE_ARG_MIN = 8'h50,
  parameter logic [DATA_W-1:0] TWO_ARG_MIN = 8'hB0
) (
  input  logic [DATA_W-1:0] opcode,
  output logic [LEN_W-1:0]  argCount
);

  // thresholds compared from the top down; a code at or above the upper one wins
  always_comb begin
    if (opcode >= TWO_ARG_MIN)      argCount = LEN_W'(2);
    else if (opcode >= ONE_ARG_MIN) argCount = LEN_W'(1);
    else                            argCount = '0;
  end

endmodule

// File: rtl/fseq_ctrl.sv
`timescale 1ns/1ps
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] inLen,
  input  logic             inHalt,
  input  logic [LEN_W-1:0] regLen,
  input  logic             execDone,
  output ctrlStrobes_t     strobes,
  output logic [LEN_W-1:0] argIdx,
  output logic             execStart,
  output logic             execClear,
  output logic             bootDone,
  output logic             halted,
  output logic             waitDone
);

  seqState_e        state, stateNext;
  logic [LEN_W-1:0] argCnt, argCntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_BOOT_HI;
      argCnt <= '0;
    end else begin
      state  <= stateNext;
      argCnt <= argCntNext;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.addrSel = ADDR_PC;
    execStart       = 1'b0;
    stateNext       = state;
    argCntNext      = argCnt;
    case (state)
      S_BOOT_HI: begin
        strobes.addrSel = ADDR_BOOT_HI;
        strobes.capHi   = 1'b1;
        stateNext       = S_BOOT_LO;
      end
      S_BOOT_LO: begin
        strobes.addrSel = ADDR_BOOT_LO;
        strobes.capLo   = 1'b1;
        stateNext       = S_BOOT_BANK;
      end
      S_BOOT_BANK: begin
        strobes.addrSel = ADDR_BOOT_BANK;
        strobes.capBank = 1'b1;
        stateNext       = S_OPCODE;
      end
      S_OPCODE: begin
        strobes.capOpcode = 1'b1;
        strobes.pcInc     = 1'b1;
        argCntNext        = '0;
        if (inHalt)               stateNext = S_HALT;
        else if (inLen == '0)     stateNext = S_ISSUE;
        else                      stateNext = S_ARG;
      end
      S_ARG: begin
        strobes.capArg = 1'b1;
        strobes.pcInc  = 1'b1;
        if (argCnt + LEN_W'(1) == regLen) stateNext = S_ISSUE;
        else argCntNext = argCnt + LEN_W'(1);
      end
      S_ISSUE: begin
        execStart = 1'b1;
        stateNext = S_WAIT;
      end
      S_WAIT: begin
        if (execDone) stateNext = S_OPCODE;
      end
      S_HALT: stateNext = S_HALT;
      default: stateNext = S_BOOT_HI;
    endcase
  end

  assign argIdx    = argCnt;
  assign execClear = (state == S_BOOT_HI);
  assign bootDone  = !(state inside {S_BOOT_HI, S_BOOT_LO, S_BOOT_BANK});
  assign halted    = (state == S_HALT);
  assign waitDone  = (state == S_WAIT);

endmodule

// File: rtl/fseq_dp.sv
`timescale 1ns/1ps
module fseq_dp
  import fseq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int MAX_ARGS = 2,
  parameter int LEN_W    = 2,
  parameter logic [DATA_W-1:0] SP_INIT = 8'hFF
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [LEN_W-1:0]           argIdx,
  input  logic [DATA_W-1:0]          memDataIn,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [DATA_W-1:0]          opcode,
  output logic [MAX_ARGS*DATA_W-1:0] args,
  output logic [ADDR_W-1:0]          pc,
  output logic [DATA_W-1:0]          bank,
  output logic [DATA_W-1:0]          sp
);

  localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BANK_ADDR = TOP_ADDR;
  localparam logic [ADDR_W-1:0] LO_ADDR   = TOP_ADDR - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] HI_ADDR   = TOP_ADDR - ADDR_W'(2);

  logic [DATA_W-1:0] hiQ, loQ;

  always_comb begin
    case (strobes.addrSel)
      ADDR_BOOT_HI:   memAddr = HI_ADDR;
      ADDR_BOOT_LO:   memAddr = LO_ADDR;
      ADDR_BOOT_BANK: memAddr = BANK_ADDR;
      default:        memAddr = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ    <= '0;
      loQ    <= '0;
      bank   <= '0;
      sp     <= '0;
      pc     <= '0;
      opcode <= '0;
    end else begin
      if (strobes.capHi) hiQ <= memDataIn;
      if (strobes.capLo) loQ <= memDataIn;
      if (strobes.capBank) begin
        bank <= memDataIn;
        sp   <= SP_INIT;
        pc   <= ADDR_W'({hiQ, loQ});
      end else if (strobes.pcInc) begin
        pc <= pc + ADDR_W'(1);
      end
      if (strobes.capOpcode) opcode <= memDataIn;
    end
  end

  for (genvar g = 0; g < MAX_ARGS; g++) begin : gArg
    logic [DATA_W-1:0] argQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          argQ <= '0;
      else if (strobes.capOpcode)                         argQ <= '0;
      else if (strobes.capArg && argIdx == LEN_W'(g))     argQ <= memDataIn;
    end
    assign args[g*DATA_W +: DATA_W] = argQ;
  end

endmodule

// File: rtl/fetch_seq.sv
`timescale 1ns/1ps
module fetch_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int MAX_ARGS = 2,
  parameter logic [DATA_W-1:0] ONE_ARG_MIN = 8'h50,
  parameter logic [DATA_W-1:0] TWO_ARG_MIN = 8'hB0,
  parameter logic [DATA_W-1:0] HALT_OP     = 8'h00,
  parameter logic [DATA_W-1:0] SP_INIT     = 8'hFF
) (
  input  logic                       clk,
  input  logic                       rstN,
  output logic [ADDR_W-1:0]          memAddr,
  output logic                       memRdWrN,
  output logic                       memDataOe,
  input  logic [DATA_W-1:0]          memDataIn,
  output logic                       execStart,
  output logic [DATA_W-1:0]          execOpcode,
  output logic [MAX_ARGS*DATA_W-1:0] execArgs,
  input  logic                       execDone,
  output logic                       execClear,
  output logic [ADDR_W-1:0]          fetchPc,
  output logic [DATA_W-1:0]          stackBank,
  output logic [DATA_W-1:0]          stackPtr,
  output logic                       bootDone,
  output logic                       halted
);

  localparam int LEN_W = $clog2(MAX_ARGS + 1);

  ctrlStrobes_t     strobes;
  logic [LEN_W-1:0] inLen, regLen, argIdx;
  logic             inHalt, waitDone;

  assign inHalt    = (memDataIn == HALT_OP);
  assign memRdWrN  = 1'b1;
  assign memDataOe = 1'b0;

  fseq_len_dec #(
    .DATA_W(DATA_W), .LEN_W(LEN_W),
    .ONE_ARG_MIN(ONE_ARG_MIN), .TWO_ARG_MIN(TWO_ARG_MIN)
  ) inDec_i (
    .opcode(memDataIn), .argCount(inLen)
  );

  fseq_len_dec #(
    .DATA_W(DATA_W), .LEN_W(LEN_W),
    .ONE_ARG_MIN(ONE_ARG_MIN), .TWO_ARG_MIN(TWO_ARG_MIN)
  ) regDec_i (
    .opcode(execOpcode), .argCount(regLen)
  );

  fseq_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .inLen(inLen), .inHalt(inHalt), .regLen(regLen), .execDone(execDone),
    .strobes(strobes), .argIdx(argIdx),
    .execStart(execStart), .execClear(execClear),
    .bootDone(bootDone), .halted(halted), .waitDone(waitDone)
  );

  fseq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_ARGS(MAX_ARGS),
    .LEN_W(LEN_W), .SP_INIT(SP_INIT)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .argIdx(argIdx), .memDataIn(memDataIn),
    .memAddr(memAddr), .opcode(execOpcode), .args(execArgs),
    .pc(fetchPc), .bank(stackBank), .sp(stackPtr)
  );

endmodule

// File: rtl/fseq_checker.sv
`timescale 1ns/1ps
module fseq_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] fetchPc,
  input logic              execStart,
  input logic              execDone,
  input logic              bootDone,
  input logic              halted,
  input logic              waitDone
);

  localparam logic [ADDR_W-1:0] TOP_A = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LO_A  = TOP_A - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] HI_A  = TOP_A - ADDR_W'(2);

  a_r3_boot_hi_then_lo: assert property (@(posedge clk) disable iff (!rstN)
    (!bootDone && memAddr == HI_A) |=> (!bootDone && memAddr == LO_A));

  a_r3_boot_lo_then_bank: assert property (@(posedge clk) disable iff (!rstN)
    (!bootDone && memAddr == LO_A) |=> (!bootDone && memAddr == TOP_A));

  a_r6_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (bootDone && !halted && !execStart && !waitDone)
      |=> (fetchPc == ADDR_W'($past(fetchPc) + 1'b1)));

  a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    execStart |=> !execStart);

  a_r8_stall_holds_pc: assert property (@(posedge clk) disable iff (!rstN)
    (waitDone && !execDone) |=> ($stable(fetchPc) && !execStart));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  a_r9_no_issue_halted: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !execStart);

endmodule

bind fetch_seq fseq_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .fetchPc(fetchPc),
  .execStart(execStart), .execDone(execDone), .bootDone(bootDone),
  .halted(halted), .waitDone(waitDone)
);

// File: tb/fetch_seq_tb.sv
`timescale 1ns/1ps
module fetch_seq_tb_top;

  localparam int K_BOOT = 0, K_READ = 1, K_START = 2, K_WAIT = 3, K_HALT = 4;

  typedef struct packed {
    logic [2:0]  kind;
    logic [11:0] addr;
    logic [11:0] pc;
    logic [7:0]  op;
    logic [7:0]  a1;
    logic [7:0]  a2;
  } ent_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] memAddr;
  logic        memRdWrN, memDataOe;
  logic [7:0]  memDataIn;
  logic        execStart;
  logic [7:0]  execOpcode;
  logic [15:0] execArgs;
  logic        execDone = 1'b0;
  logic        execClear;
  logic [11:0] fetchPc;
  logic [7:0]  stackBank, stackPtr;
  logic        bootDone, halted;

  logic [7:0]  mem [4096];
  ent_t        tq[$];
  int          checks = 0;
  int          errors = 0;
  int          expBank = 0;

  always #4 clk = ~clk;

  assign memDataIn = mem[memAddr];

  fetch_seq dut_i (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRdWrN(memRdWrN),
    .memDataOe(memDataOe), .memDataIn(memDataIn), .execStart(execStart),
    .execOpcode(execOpcode), .execArgs(execArgs), .execDone(execDone),
    .execClear(execClear), .fetchPc(fetchPc), .stackBank(stackBank),
    .stackPtr(stackPtr), .bootDone(bootDone), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int latencyOf(input int op);
    return 1 + (op % 3);
  endfunction

  function automatic void pushEnt(input int kind, input int addr, input int pc,
                                  input int op, input int a1, input int a2);
    ent_t e;
    e.kind = 3'(kind); e.addr = 12'(addr); e.pc = 12'(pc);
    e.op = 8'(op); e.a1 = 8'(a1); e.a2 = 8'(a2);
    tq.push_back(e);
  endfunction

  // walk the memory image and list what each cycle must show
  task automatic buildTrace();
    int pc, op, na, a1, a2;
    tq.delete();
    pushEnt(K_BOOT, 12'hFFD, 0, 0, 0, 0);
    pushEnt(K_BOOT, 12'hFFE, 0, 0, 0, 0);
    pushEnt(K_BOOT, 12'hFFF, 0, 0, 0, 0);
    pc = ((int'(mem[12'hFFD]) << 8) + int'(mem[12'hFFE])) % 4096;
    expBank = int'(mem[12'hFFF]);
    for (int n = 0; n < 200; n++) begin
      op = int'(mem[pc]);
      pushEnt(K_READ, pc, pc, 0, 0, 0);
      pc = (pc + 1) % 4096;
      if (op == 0) begin
        pushEnt(K_HALT, 0, pc, 0, 0, 0);
        break;
      end
      na = (op >= 'hB0) ? 2 : (op >= 'h50) ? 1 : 0;
      a1 = 0; a2 = 0;
      if (na >= 1) begin
        pushEnt(K_READ, pc, pc, 0, 0, 0);
        a1 = int'(mem[pc]); pc = (pc + 1) % 4096;
      end
      if (na == 2) begin
        pushEnt(K_READ, pc, pc, 0, 0, 0);
        a2 = int'(mem[pc]); pc = (pc + 1) % 4096;
      end
      pushEnt(K_START, 0, pc, op, a1, a2);
      for (int w = 0; w < latencyOf(op); w++) pushEnt(K_WAIT, 0, pc, 0, 0, 0);
    end
  endtask

  task automatic checkEntry(input ent_t e);
    chk(memRdWrN == 1'b1 && memDataOe == 1'b0, "R1", "rdwr/oe",
        int'({memRdWrN, memDataOe}), 2);
    if (int'(e.kind) == K_BOOT) begin
      chk(memAddr == e.addr, "R3", "boot address", int'(memAddr), int'(e.addr));
      chk(bootDone == 1'b0, "R3", "bootDone in boot", int'(bootDone), 0);
      chk(execClear == (e.addr == 12'hFFD), "R4", "execClear in boot",
          int'(execClear), int'(e.addr == 12'hFFD));
      chk(fetchPc == 12'h000, "R6", "pc in boot", int'(fetchPc), 0);
      chk(stackBank == 8'h00 && stackPtr == 8'h00, "R3", "stack before load",
          int'({stackBank, stackPtr}), 0);
      chk(execStart == 1'b0, "R7", "no start in boot", int'(execStart), 0);
    end else begin
      chk(bootDone == 1'b1, "R3", "bootDone", int'(bootDone), 1);
      chk(execClear == 1'b0, "R4", "execClear after boot", int'(execClear), 0);
      chk(fetchPc == e.pc, "R6", "fetchPc", int'(fetchPc), int'(e.pc));
      chk(int'(stackBank) == expBank, "R3", "stackBank", int'(stackBank), expBank);
      chk(stackPtr == 8'hFF, "R3", "stackPtr", int'(stackPtr), 'hFF);
      chk(halted == (int'(e.kind) == K_HALT), "R9", "halted",
          int'(halted), int'(int'(e.kind) == K_HALT));
      case (int'(e.kind))
        K_READ: begin
          chk(memAddr == e.addr, "R5", "fetch address", int'(memAddr), int'(e.addr));
          chk(execStart == 1'b0, "R5", "no start while fetching", int'(execStart), 0);
        end
        K_START: begin
          chk(execStart == 1'b1, "R7", "start pulse", int'(execStart), 1);
          chk(execOpcode == e.op, "R10", "issued opcode", int'(execOpcode), int'(e.op));
          chk(execArgs == {e.a2, e.a1}, "R7", "issued operands",
              int'(execArgs), int'({e.a2, e.a1}));
        end
        K_WAIT: chk(execStart == 1'b0, "R8", "no start while waiting", int'(execStart), 0);
        default: chk(execStart == 1'b0, "R9", "no start when halted", int'(execStart), 0);
      endcase
    end
  endtask

  // compares every cycle; plays the execute stage; stops early after stopAfter cycles
  task automatic runTrace(input int stopAfter);
    int idx = 0, cnt = 0, haltSeen = 0;
    ent_t e;
    for (int c = 0; c < 5000; c++) begin
      #1;
      e = tq[idx];
      checkEntry(e);
      execDone = 1'b0;
      if (int'(e.kind) == K_START) cnt = latencyOf(int'(e.op));
      if (int'(e.kind) == K_WAIT) begin
        cnt--;
        if (cnt == 0) execDone = 1'b1;
      end
      if (int'(e.kind) == K_HALT) begin
        haltSeen++;
        if (haltSeen == 8) return;
      end else begin
        idx++;
      end
      if (c + 1 == stopAfter) return;
      @(negedge clk);
    end
    chk(1'b0, "R9", "program did not reach halt", 0, 1);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    execDone = 1'b0;
    #1;
    chk(memAddr == 12'hFFD, "R2", "addr in reset", int'(memAddr), 'hFFD);
    chk(halted == 1'b0, "R2", "halted cleared by reset", int'(halted), 0);
    chk(bootDone == 1'b0 && execStart == 1'b0, "R2", "bootDone/start in reset",
        int'({bootDone, execStart}), 0);
    chk(fetchPc == 12'h000, "R2", "pc in reset", int'(fetchPc), 0);
    chk(stackBank == 8'h00 && stackPtr == 8'h00, "R2", "stack in reset",
        int'({stackBank, stackPtr}), 0);
    chk(execClear == 1'b1, "R4", "clear in reset", int'(execClear), 1);
    chk(memRdWrN == 1'b1 && memDataOe == 1'b0, "R1", "rdwr/oe in reset",
        int'({memRdWrN, memDataOe}), 2);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  // program A: thresholds on both sides, an unassigned code, then halt
  task automatic loadProgA();
    clearMem();
    mem[12'hFFD] = 8'h01; mem[12'hFFE] = 8'h23; mem[12'hFFF] = 8'h0E;
    mem[12'h123] = 8'h4F;
    mem[12'h124] = 8'h50; mem[12'h125] = 8'hA5;
    mem[12'h126] = 8'hAF; mem[12'h127] = 8'h3C;
    mem[12'h128] = 8'hB0; mem[12'h129] = 8'h12; mem[12'h12A] = 8'h34;
    mem[12'h12B] = 8'hFF; mem[12'h12C] = 8'h01; mem[12'h12D] = 8'h02;
    mem[12'h12E] = 8'h33;
    mem[12'h12F] = 8'h01;
    mem[12'h130] = 8'h00;
  endtask

  // program B: start address masked to 12 bits, runs through the boot bytes and wraps
  task automatic loadProgB();
    clearMem();
    mem[12'hFFD] = 8'hFF; mem[12'hFFE] = 8'hF8; mem[12'hFFF] = 8'h07;
    mem[12'hFF8] = 8'h54; mem[12'hFF9] = 8'h77;
    mem[12'hFFA] = 8'h0A;
    mem[12'hFFB] = 8'hB1; mem[12'hFFC] = 8'h22;
    mem[12'h000] = 8'h62;
    mem[12'h001] = 8'h80; mem[12'h002] = 8'h00;
    mem[12'h003] = 8'h00;
  endtask

  initial begin
    clearMem();
    // R2: reset state, R3/R5/R7/R8/R9/R10: program A to halt
    loadProgA();
    buildTrace();
    applyReset();
    runTrace(0);
    // R9: halt cleared by reset; R3/R6: masked start and wrap
    loadProgB();
    buildTrace();
    applyReset();
    runTrace(0);
    // R2: reset in mid-run, then a clean reboot
    loadProgA();
    buildTrace();
    applyReset();
    runTrace(25);
    applyReset();
    runTrace(0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule